// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block holds the interrupt state of a serial bus controller. Ten source lines arrive from the bus engine, and each line belongs to one of two kinds. A sticky source latches its event into the status register and keeps the flag set until software writes a one to that bit. A level source copies its condition into the status register on every clock, so its flag stays set only while the condition holds. Bit 8 has no source and always reads zero.

Software sees four register selects. One select reads the status register, and a write through it clears sticky flags with write-one-to-clear. A second select reads the mask, which cannot be written. The last two selects are write-only ports: a one written through the enable port clears a mask bit, and a one written through the disable port sets a mask bit. A mask bit of one blocks its source. After reset every valid source is masked. The single interrupt request output is registered. It is the OR, over the valid bits, of each status bit that is not masked.

The block has no state machine. Each status bit and each mask bit is its own flop, and its next value is a fixed function of the source, the flop itself and the decoded write. The register select encoding is 0 for status, 1 for mask, 2 for enable and 3 for disable.

Top module: `irq_status_unit`

## Requirements
- R1: While reset is applied and right after it, the status reads 0x000, the mask reads 0x2FF and `irq` is 0.
- R2: A write to select 2 (enable) clears every mask bit where the written data holds a 1. Mask bits where the data holds a 0 keep their value. The new mask is visible one clock after the write.
- R3: A write to select 3 (disable) sets every valid mask bit where the written data holds a 1. The new mask is visible one clock after the write.
- R4: A write to select 1 (mask) changes nothing, and reads of selects 2 and 3 return zero.
- R5: Sticky sources are bit 0 (transfer complete), bit 2 (no-acknowledge), bit 3 (timeout), bit 4 (monitored target ready) and bit 9 (arbitration lost). When one of these sources is high at a clock edge, its status bit reads 1 from the next cycle on. It stays 1 until software clears it.
- R6: A write to select 0 (status) clears each sticky bit where the data holds a 1. If the source of that bit is high in the same cycle, the bit stays set.
- R7: Level sources are bit 1 (data), bit 5 (receive overflow), bit 6 (transmit overflow) and bit 7 (receive underflow). Each of these status bits equals its source as sampled at the previous clock edge, whether or not a clear is written.
- R8: Status bit 8 and mask bit 8 always read 0, even when source 8 is driven high or an enable or disable write carries a 1 in bit 8.
- R9: `irq` is high exactly when, in the previous cycle, some valid status bit was 1 while its mask bit was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 10 | Source lines: event pulses for sticky bits, conditions for level bits |
| wr_en | input | 1 | Write strobe for the register selected by `wr_sel` |
| wr_sel | input | 2 | Write select: 0 status, 1 mask, 2 enable, 3 disable |
| wr_data | input | 10 | Write data, one bit per source |
| rd_sel | input | 2 | Read select, same encoding as `wr_sel` |
| rd_data | output | 10 | Combinational read data for `rd_sel` |
| irq | output | 1 | Registered combined interrupt request |

## Verification
If a status or mask flop holds a wrong value, a read of that register shows it in the very next cycle. Through `irq`, the same fault appears one clock later, unless the bit is masked or another pending source hides it. A sticky bit that is wrongly reloaded or lost is different. It only shows after a later clear or a later event, so the bench keeps a reference model that runs alongside the design. It compares both `rd_data` and `irq` on every cycle, including the case where a clear and an event hit the same cycle.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

    typedef enum logic [1:0] {
        SEL_STATUS  = 2'd0,
        SEL_MASK    = 2'd1,
        SEL_ENABLE  = 2'd2,
        SEL_DISABLE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int             NSRC  = 10,
    parameter logic [NSRC-1:0] VALID = 10'h2FF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_hit,
    input  logic            dis_hit,
    input  logic [NSRC-1:0] data,
    output logic [NSRC-1:0] mask_q
);

    logic [NSRC-1:0] data_v;

    assign data_v = data & VALID;

    // inverted-sense mask: one blocks the source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= VALID;
        end else if (en_hit) begin
            mask_q <= mask_q & ~data_v;
        end else if (dis_hit) begin
            mask_q <= mask_q | data_v;
        end
    end

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int             NSRC   = 10,
    parameter logic [NSRC-1:0] VALID  = 10'h2FF,
    parameter logic [NSRC-1:0] STICKY = 10'h21D
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic [NSRC-1:0] clr_vec,
    output logic [NSRC-1:0] status_q
);

    genvar i;
    generate
        for (i = 0; i < NSRC; i++) begin : g_bit
            localparam logic KEEP = STICKY[i];
            localparam logic LIVE = VALID[i];
            logic nxt;

            // a sticky bit holds until cleared, and an event beats the clear;
            // a level bit simply copies its condition
            assign nxt = LIVE & (src_in[i] | (KEEP & status_q[i] & ~clr_vec[i]));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    status_q[i] <= 1'b0;
                end else begin
                    status_q[i] <= nxt;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
    parameter int             NSRC  = 10,
    parameter logic [NSRC-1:0] VALID = 10'h2FF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] status_q,
    input  logic [NSRC-1:0] mask_q,
    output logic            irq_q
);

    logic [NSRC-1:0] pending;

    assign pending = status_q & ~mask_q & VALID;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |pending;
        end
    end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_unit_pkg::*;
#(
    parameter int             NSRC        = 10,
    parameter logic [NSRC-1:0] VALID_MASK  = 10'h2FF,
    parameter logic [NSRC-1:0] STICKY_MASK = 10'h21D
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [NSRC-1:0] wr_data,
    input  logic [1:0]      rd_sel,
    output logic [NSRC-1:0] rd_data,
    output logic            irq
);

    reg_sel_e        wsel;
    reg_sel_e        rsel;
    logic            clr_hit;
    logic            en_hit;
    logic            dis_hit;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] status_q;
    logic [NSRC-1:0] mask_q;

    assign wsel    = reg_sel_e'(wr_sel);
    assign rsel    = reg_sel_e'(rd_sel);
    assign clr_hit = wr_en && (wsel == SEL_STATUS);
    assign en_hit  = wr_en && (wsel == SEL_ENABLE);
    assign dis_hit = wr_en && (wsel == SEL_DISABLE);
    assign clr_vec = clr_hit ? wr_data : '0;

    irq_status_reg #(
        .NSRC   (NSRC),
        .VALID  (VALID_MASK),
        .STICKY (STICKY_MASK)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .clr_vec  (clr_vec),
        .status_q (status_q)
    );

    irq_mask_reg #(
        .NSRC  (NSRC),
        .VALID (VALID_MASK)
    ) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_hit  (en_hit),
        .dis_hit (dis_hit),
        .data    (wr_data),
        .mask_q  (mask_q)
    );

    irq_req_gen #(
        .NSRC  (NSRC),
        .VALID (VALID_MASK)
    ) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_q (status_q),
        .mask_q   (mask_q),
        .irq_q    (irq)
    );

    always_comb begin
        unique case (rsel)
            SEL_STATUS:  rd_data = status_q;
            SEL_MASK:    rd_data = mask_q;
            SEL_ENABLE:  rd_data = '0;
            SEL_DISABLE: rd_data = '0;
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
    parameter int             NSRC   = 10,
    parameter logic [NSRC-1:0] VALID  = 10'h2FF,
    parameter logic [NSRC-1:0] STICKY = 10'h21D
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_in,
    input logic            wr_en,
    input logic [1:0]      wr_sel,
    input logic [NSRC-1:0] wr_data,
    input logic [1:0]      rd_sel,
    input logic [NSRC-1:0] rd_data,
    input logic            irq,
    input logic [NSRC-1:0] status_q,
    input logic [NSRC-1:0] mask_q
);

    localparam logic [NSRC-1:0] LEVEL = VALID & ~STICKY;

    AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_en) && ($past(wr_sel) == 2'd2)
        |-> ((mask_q & $past(wr_data) & VALID) == '0)); // R2

    AST_DISABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_en) && ($past(wr_sel) == 2'd3)
        |-> (($past(wr_data) & VALID & ~mask_q) == '0)); // R3

    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !($past(wr_en) && $past(wr_sel[1]))
        |-> (mask_q == $past(mask_q))); // R4

    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel[1] |-> (rd_data == '0)); // R4

    AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !($past(wr_en) && ($past(wr_sel) == 2'd0))
        |-> (($past(status_q) & STICKY & ~status_q) == '0)); // R5

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n)
        |-> (($past(src_in) & STICKY & VALID & ~status_q) == '0)); // R6

    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n)
        |-> ((status_q & LEVEL) == ($past(src_in) & LEVEL))); // R7

    AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q | mask_q) & ~VALID) == '0); // R8

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n)
        |-> (irq == (|($past(status_q) & ~$past(mask_q) & VALID)))); // R9

endmodule

bind irq_status_unit irq_status_unit_chk #(
    .NSRC   (NSRC),
    .VALID  (VALID_MASK),
    .STICKY (STICKY_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_in   (src_in),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .irq      (irq),
    .status_q (status_q),
    .mask_q   (mask_q)
);

// File: tb/irq_status_unit_test.sv
`timescale 1ns/1ps
module irq_status_unit_test;

    localparam logic [1:0] S_ST = 2'd0;
    localparam logic [1:0] S_MK = 2'd1;
    localparam logic [1:0] S_EN = 2'd2;
    localparam logic [1:0] S_DI = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] src_in = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [9:0] wr_data = '0;
    logic [1:0] rd_sel = '0;
    logic [9:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [9:0] m_st;
    logic [9:0] m_mk;
    logic       m_irq;
    int sticky_list[$] = '{0, 2, 3, 4, 9};
    int level_list[$]  = '{1, 5, 6, 7};

    always #2 clk = ~clk;

    irq_status_unit uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_in  (src_in),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .irq     (irq)
    );

    function automatic logic [9:0] model_read(input logic [1:0] rs);
        if (rs == S_ST) return m_st;
        if (rs == S_MK) return m_mk;
        return 10'h000;
    endfunction

    task automatic compare(input logic [9:0] act, input logic [9:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%03h expected 0x%03h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic [9:0] s, input logic we, input logic [1:0] ws,
                              input logic [9:0] wd);
        logic [9:0] n_st;
        logic [9:0] n_mk;
        int pend;
        pend = 0;
        for (int b = 0; b < 10; b++) begin
            if (b != 8 && m_st[b] && !m_mk[b]) pend = 1;
        end
        n_st = '0;
        foreach (sticky_list[k]) begin
            int b;
            b = sticky_list[k];
            if (s[b]) n_st[b] = 1'b1;
            else if (m_st[b] && !(we && ws == S_ST && wd[b])) n_st[b] = 1'b1;
        end
        foreach (level_list[k]) n_st[level_list[k]] = s[level_list[k]];
        n_mk = m_mk;
        if (we && ws == S_EN) begin
            for (int b = 0; b < 10; b++) if (wd[b]) n_mk[b] = 1'b0;
        end else if (we && ws == S_DI) begin
            for (int b = 0; b < 10; b++) if (wd[b] && b != 8) n_mk[b] = 1'b1;
        end
        m_st  = n_st;
        m_mk  = n_mk;
        m_irq = (pend != 0);
    endtask

    // one clock: apply inputs after the falling edge, compare, then advance
    task automatic cyc(input logic [9:0] s, input logic we, input logic [1:0] ws,
                       input logic [9:0] wd, input logic [1:0] rs, input string tag);
        src_in = s; wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs;
        #1;
        compare(rd_data, model_read(rs), tag);
        compare({9'b0, irq}, {9'b0, m_irq}, {tag, "/R9 irq"});
        @(posedge clk);
        model_step(s, we, ws, wd);
        @(negedge clk);
    endtask

    task automatic idle(input logic [1:0] rs, input string tag);
        cyc(10'h000, 1'b0, S_ST, 10'h000, rs, tag);
    endtask

    initial begin
        #(4 * 50000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_st = '0; m_mk = 10'h2FF; m_irq = 1'b0;
        repeat (3) @(negedge clk);
        // R1: values held in reset
        #1;
        compare(rd_data, 10'h000, "R1 status in reset");
        compare({9'b0, irq}, 10'h000, "R1 irq in reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle(S_ST, "R1 status");
        idle(S_MK, "R1 mask");

        // R2 / R4 enable everything, try read-only and write-only paths
        cyc(10'h000, 1'b1, S_EN, 10'h3FF, S_EN, "R4 enable reads zero");
        idle(S_MK, "R2 mask after enable all");
        cyc(10'h000, 1'b1, S_MK, 10'h2FF, S_MK, "R4 mask write");
        idle(S_MK, "R4 mask unchanged");
        idle(S_DI, "R4 disable reads zero");

        // R3 partial disable, R2 partial enable
        cyc(10'h000, 1'b1, S_DI, 10'h005, S_MK, "R3 disable write");
        idle(S_MK, "R3 mask 0x005");
        cyc(10'h000, 1'b1, S_EN, 10'h001, S_MK, "R2 enable write");
        idle(S_MK, "R2 mask 0x004");

        // R5 sticky latch on masked and unmasked bits
        cyc(10'h004, 1'b0, S_ST, 10'h000, S_ST, "R5 event bit2");
        idle(S_ST, "R5 bit2 latched");
        idle(S_ST, "R9 masked bit2 silent");
        cyc(10'h008, 1'b0, S_ST, 10'h000, S_ST, "R5 event bit3");
        idle(S_ST, "R5 bit3 latched");
        idle(S_ST, "R9 bit3 raises irq");

        // R6 clear, and event beating the clear
        cyc(10'h000, 1'b1, S_ST, 10'h008, S_ST, "R6 clear bit3");
        idle(S_ST, "R6 bit3 cleared");
        cyc(10'h001, 1'b0, S_ST, 10'h000, S_ST, "R5 event bit0");
        cyc(10'h001, 1'b1, S_ST, 10'h001, S_ST, "R6 clear with event");
        idle(S_ST, "R6 event wins");
        cyc(10'h000, 1'b1, S_ST, 10'h3FF, S_ST, "R6 clear all");
        idle(S_ST, "R6 all sticky cleared");

        // R7 level bit follows its condition despite a clear
        cyc(10'h002, 1'b0, S_ST, 10'h000, S_ST, "R7 cond rises");
        cyc(10'h002, 1'b1, S_ST, 10'h002, S_ST, "R7 clear ignored");
        cyc(10'h0E2, 1'b0, S_ST, 10'h000, S_ST, "R7 still set");
        idle(S_ST, "R7 levels set");
        idle(S_ST, "R7 cond dropped");

        // R8 hole bit never sets
        cyc(10'h100, 1'b1, S_EN, 10'h100, S_ST, "R8 enable hole");
        cyc(10'h100, 1'b1, S_DI, 10'h100, S_ST, "R8 source hole");
        idle(S_ST, "R8 status bit8");
        idle(S_MK, "R8 mask bit8");

        // R3 mask everything, R9 irq falls
        cyc(10'h210, 1'b0, S_ST, 10'h000, S_ST, "R5 events 4 and 9");
        idle(S_ST, "R9 irq pending");
        cyc(10'h000, 1'b1, S_DI, 10'h3FF, S_MK, "R3 disable all");
        idle(S_MK, "R3 mask full");
        idle(S_ST, "R9 irq cleared by mask");

        // random traffic against the model
        for (int n = 0; n < 600; n++) begin
            logic [9:0] s;
            logic       we;
            s  = 10'($urandom) & 10'($urandom);
            we = ($urandom % 3) == 0;
            cyc(s, we, 2'($urandom), 10'($urandom), 2'($urandom), "R9 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule